// File: doc/BRIEF.md
# Transaction-to-Flit Packetizer

This block turns core-side write transactions into packets for a wormhole-switched on-chip network. A core offers one request that carries a target address and a burst length. It then supplies the data beats of that request on a separate data channel. The block latches the address once, into a header register. It looks up a source route in a small programmable table, using the top address bits as the index, and emits a single header flit that carries that route. Each data beat passes through a payload register that is refilled for every beat. Each beat leaves as a body flit, except the last one, which is marked as the tail.

On the network side, a two-entry flit buffer decouples the packetizer from downstream back-pressure. A flit leaves only while the downstream ready is high. A new request is taken only after the tail of the previous packet has been written into that buffer, so the flits of one packet never mix with those of the next.

Top module: `txn_flit_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, `wdat_ready` is 0 and `flit_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the next cycle. It returns high only in the cycle after the tail flit of that packet has been written into the buffer.
- R3: Each taken request produces exactly one header flit, and that flit comes before all data flits of the packet. Its type field `flit_data[49:48]` is 01. Its payload holds the route in `[47:36]`, `req_len` in `[35:32]` and the address in `[31:0]`. `flit_valid` is never high with a type field of 00.
- R4: A request with `req_len` = L carries L+1 data beats. These leave as L body flits (type 10) followed by one tail flit (type 11). Each data flit carries its beat in `[31:0]`, with bits `[47:32]` zero, in the order the beats were accepted.
- R5: A request with `req_len` = 0 produces exactly two flits: a header flit followed by a tail flit.
- R6: The route in a header is the table entry indexed by `req_addr[31:28]`, read at the edge where the request is taken. A table write (`rt_we`, `rt_idx`, `rt_route`) affects requests taken on later edges. Every entry resets to 0.
- R7: While `flit_valid` is 1 and `flit_ready` is 0, `flit_valid` stays 1 and `flit_data` stays unchanged. No flit is lost, duplicated or reordered.
- R8: The buffer holds at most two flits. With `flit_ready` held low, a request of three or more beats has exactly two data beats accepted: one waits in the buffer behind the header, and one waits in the payload register.
- R9: `wdat_ready` is 0 while no request is in progress. Data offered there is not taken and produces no flit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_we | input | 1 | Route table write strobe |
| rt_idx | input | 4 | Route table entry to write |
| rt_route | input | 12 | Route value to write |
| req_valid | input | 1 | Core request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Target address of the request |
| req_len | input | 4 | Number of data beats minus one |
| wdat_valid | input | 1 | Data beat offered |
| wdat_ready | output | 1 | Block takes the data beat |
| wdat_data | input | 32 | Data beat |
| flit_valid | output | 1 | Flit available to the network |
| flit_ready | input | 1 | Network takes the flit |
| flit_data | output | 50 | Flit: type in [49:48], payload below |

## Verification
The assertions check the following on every cycle:
- packet framing: a header push only outside a packet, body and tail pushes only inside one, and never more than one push per cycle;
- the request gate around the tail push, and that `wdat_ready` stays low while idle;
- the legal type field on the output;
- the hold rule under back-pressure;
- the buffer level bound.

Only the bench scenarios can show the rest. This covers the header's route, length and address fields and the body/tail marking on the last beat. It also covers the effect of a table write on a later packet and the exact number of beats absorbed while the network stalls. These depend on matching output flits against a model of the transactions sent.

// File: rtl/ni_pkg.sv
package ni_pkg;

  localparam int FT_W = 2;

  typedef enum logic [1:0] {
    FT_NONE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flit_type_e;

  typedef enum logic [1:0] {
    PK_IDLE = 2'b00,
    PK_HEAD = 2'b01,
    PK_DATA = 2'b10
  } pk_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ni_route_lut.sv
module ni_route_lut #(
  parameter int IDX_W   = 4,
  parameter int ROUTE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ROUTE_W-1:0] wr_route,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ROUTE_W-1:0] rd_route
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ROUTE_W-1:0] entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        entry_q[g] <= wr_route;
      end
    end
  end

  assign rd_route = entry_q[rd_idx];

endmodule

// File: rtl/ni_flit_buf.sv
module ni_flit_buf #(
  parameter int W     = 50,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head_data,
  output logic             full,
  output logic             empty,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (do_push && (wr_ptr_q == PTR_W'(g))) begin
        slot_q[g] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_data = slot_q[rd_ptr_q];
  assign level     = cnt_q;

endmodule

// File: rtl/ni_packetizer.sv
module ni_packetizer
  import ni_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 4,
  parameter int ROUTE_W = 12,
  parameter int PAY_W   = 48,
  parameter int FLIT_W  = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [ROUTE_W-1:0] lut_route,
  input  logic               wdat_valid,
  output logic               wdat_ready,
  input  logic [DATA_W-1:0]  wdat_data,
  input  logic               buf_full,
  output logic               push_valid,
  output logic [FLIT_W-1:0]  push_flit,
  output logic               ev_accept,
  output logic               ev_take,
  output logic               ev_hdr,
  output logic               ev_body,
  output logic               ev_tail
);

  localparam int TCNT_W = LEN_W + 1;

  pk_state_e          state_q, state_d;
  logic [ADDR_W-1:0]  hdr_addr_q;
  logic [LEN_W-1:0]   hdr_len_q;
  logic [ROUTE_W-1:0] hdr_route_q;
  logic [DATA_W-1:0]  pay_data_q;
  logic               pay_full_q;
  logic [TCNT_W-1:0]  taken_q;
  logic [LEN_W-1:0]   sent_q;

  logic take_open, pay_push, hdr_fire, last_beat;

  function automatic logic [FLIT_W-1:0] make_header(
    input logic [ROUTE_W-1:0] route,
    input logic [LEN_W-1:0]   len,
    input logic [ADDR_W-1:0]  addr
  );
    logic [PAY_W-1:0] body;
    body = PAY_W'({route, len, addr});
    return {FT_HEAD, body};
  endfunction

  function automatic logic [FLIT_W-1:0] make_data(
    input logic              is_last,
    input logic [DATA_W-1:0] data
  );
    flit_type_e t;
    t = is_last ? FT_TAIL : FT_BODY;
    return {t, PAY_W'(data)};
  endfunction

  assign req_ready = (state_q == PK_IDLE);
  assign ev_accept = req_valid && req_ready;

  assign take_open  = (taken_q <= {1'b0, hdr_len_q});
  assign last_beat  = (sent_q == hdr_len_q);
  assign pay_push   = (state_q == PK_DATA) && pay_full_q && !buf_full;
  assign hdr_fire   = (state_q == PK_HEAD) && !buf_full;
  assign wdat_ready = (state_q == PK_DATA) && take_open && (!pay_full_q || pay_push);
  assign ev_take    = wdat_valid && wdat_ready;

  always_comb begin
    push_valid = 1'b0;
    push_flit  = '0;
    unique case (state_q)
      PK_HEAD: begin
        push_valid = 1'b1;
        push_flit  = make_header(hdr_route_q, hdr_len_q, hdr_addr_q);
      end
      PK_DATA: begin
        push_valid = pay_full_q;
        push_flit  = make_data(last_beat, pay_data_q);
      end
      default: begin
        push_valid = 1'b0;
        push_flit  = '0;
      end
    endcase
  end

  assign ev_hdr  = hdr_fire;
  assign ev_body = pay_push && !last_beat;
  assign ev_tail = pay_push && last_beat;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PK_IDLE: if (ev_accept) state_d = PK_HEAD;
      PK_HEAD: if (hdr_fire)  state_d = PK_DATA;
      PK_DATA: if (ev_tail)   state_d = PK_IDLE;
      default: state_d = PK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= PK_IDLE;
      hdr_addr_q  <= '0;
      hdr_len_q   <= '0;
      hdr_route_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        hdr_addr_q  <= req_addr;
        hdr_len_q   <= req_len;
        hdr_route_q <= lut_route;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_data_q <= '0;
      pay_full_q <= 1'b0;
      taken_q    <= '0;
      sent_q     <= '0;
    end else begin
      if (ev_accept) begin
        taken_q <= '0;
        sent_q  <= '0;
      end else begin
        if (ev_take)  taken_q <= taken_q + TCNT_W'(1);
        if (pay_push) sent_q  <= sent_q + LEN_W'(1);
      end
      if (ev_take) begin
        pay_data_q <= wdat_data;
        pay_full_q <= 1'b1;
      end else if (pay_push) begin
        pay_full_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txn_flit_bridge.sv
module txn_flit_bridge
  import ni_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 4,
  parameter int ROUTE_W   = 12,
  parameter int IDX_W     = 4,
  parameter int BUF_DEPTH = 2,
  localparam int PAY_W    = imax(ROUTE_W + LEN_W + ADDR_W, DATA_W),
  localparam int FLIT_W   = FT_W + PAY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rt_we,
  input  logic [IDX_W-1:0]   rt_idx,
  input  logic [ROUTE_W-1:0] rt_route,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               wdat_valid,
  output logic               wdat_ready,
  input  logic [DATA_W-1:0]  wdat_data,
  output logic               flit_valid,
  input  logic               flit_ready,
  output logic [FLIT_W-1:0]  flit_data
);

  localparam int LVL_W = $clog2(BUF_DEPTH + 1);

  logic [ROUTE_W-1:0] lut_route;
  logic               buf_full, buf_empty;
  logic [LVL_W-1:0]   buf_level;
  logic               push_valid, push_fire;
  logic [FLIT_W-1:0]  push_flit;
  logic               ev_accept, ev_take, ev_hdr, ev_body, ev_tail;

  ni_route_lut #(
    .IDX_W  (IDX_W),
    .ROUTE_W(ROUTE_W)
  ) u_lut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rt_we),
    .wr_idx  (rt_idx),
    .wr_route(rt_route),
    .rd_idx  (req_addr[ADDR_W-1 -: IDX_W]),
    .rd_route(lut_route)
  );

  ni_packetizer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .ROUTE_W(ROUTE_W),
    .PAY_W  (PAY_W),
    .FLIT_W (FLIT_W)
  ) u_pkt (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .lut_route (lut_route),
    .wdat_valid(wdat_valid),
    .wdat_ready(wdat_ready),
    .wdat_data (wdat_data),
    .buf_full  (buf_full),
    .push_valid(push_valid),
    .push_flit (push_flit),
    .ev_accept (ev_accept),
    .ev_take   (ev_take),
    .ev_hdr    (ev_hdr),
    .ev_body   (ev_body),
    .ev_tail   (ev_tail)
  );

  assign push_fire = push_valid && !buf_full;

  ni_flit_buf #(
    .W    (FLIT_W),
    .DEPTH(BUF_DEPTH)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_fire),
    .push_data(push_flit),
    .pop      (flit_ready),
    .head_data(flit_data),
    .full     (buf_full),
    .empty    (buf_empty),
    .level    (buf_level)
  );

  assign flit_valid = !buf_empty;

endmodule

// File: rtl/ni_bridge_chk.sv
module ni_bridge_chk #(
  parameter int FLIT_W = 50,
  parameter int DEPTH  = 2,
  parameter int LVL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wdat_ready,
  input logic              flit_valid,
  input logic              flit_ready,
  input logic [FLIT_W-1:0] flit_data,
  input logic              ev_hdr,
  input logic              ev_body,
  input logic              ev_tail,
  input logic [LVL_W-1:0]  buf_level
);

  logic in_pkt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       in_pkt_q <= 1'b0;
    else if (ev_hdr)  in_pkt_q <= 1'b1;
    else if (ev_tail) in_pkt_q <= 1'b0;
  end

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R2
  AST_REOPEN_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tail |=> req_ready); // R2
  AST_IDLE_OUTSIDE_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !in_pkt_q); // R2
  AST_HDR_STARTS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr |-> !in_pkt_q); // R3
  AST_TYPE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> (flit_data[FLIT_W-1 -: 2] != 2'b00)); // R3
  AST_DATA_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_body || ev_tail) |-> in_pkt_q); // R4
  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_hdr, ev_body, ev_tail})); // R4
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && !flit_ready |=> flit_valid && $stable(flit_data)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= LVL_W'(DEPTH)); // R8
  AST_NO_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wdat_ready); // R9

endmodule

bind txn_flit_bridge ni_bridge_chk #(
  .FLIT_W(FLIT_W),
  .DEPTH (BUF_DEPTH),
  .LVL_W (LVL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wdat_ready(wdat_ready),
  .flit_valid(flit_valid),
  .flit_ready(flit_ready),
  .flit_data (flit_data),
  .ev_hdr    (ev_hdr),
  .ev_body   (ev_body),
  .ev_tail   (ev_tail),
  .buf_level (buf_level)
);

// File: tb/txn_flit_bridge_tb_top.sv
`timescale 1ns/1ps
module txn_flit_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rt_we = 1'b0;
  logic [3:0]  rt_idx = '0;
  logic [11:0] rt_route = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = '0;
  logic        wdat_valid = 1'b0;
  logic        wdat_ready;
  logic [31:0] wdat_data = '0;
  logic        flit_valid;
  logic        flit_ready;
  logic [49:0] flit_data;

  int n_checks = 0;
  int n_fails  = 0;
  int rdy_mode = 0;
  int rdy_cnt  = 0;
  int beats_taken = 0;
  bit done = 0;

  logic [11:0] route_m [16];
  logic [49:0] exp_q [$];
  logic [49:0] cap_q [$];

  always #10 clk = ~clk;

  txn_flit_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_route(rt_route),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data)
  );

  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    case (rdy_mode)
      0: flit_ready <= 1'b1;
      1: flit_ready <= (rdy_cnt % 3) != 0;
      default: flit_ready <= 1'b0;
    endcase
  end

  always begin
    @(negedge clk);
    #5;
    if (rst_n && flit_valid && flit_ready) cap_q.push_back(flit_data);
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic program_route(input logic [3:0] idx, input logic [11:0] r);
    @(negedge clk);
    rt_we = 1'b1; rt_idx = idx; rt_route = r;
    @(negedge clk);
    rt_we = 1'b0;
    route_m[idx] = r;
  endtask

  task automatic send_txn(input logic [31:0] addr, input logic [3:0] len, input logic [31:0] seed);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_len = len;
    forever begin
      #1 ok = req_ready;
      @(negedge clk);
      if (ok) break;
    end
    req_valid = 1'b0;
    exp_q.push_back({2'b01, route_m[addr[31:28]], len, addr});
    for (int i = 0; i <= len; i++) begin
      logic [31:0] d;
      d = seed ^ (32'h9e37_79b9 * (i + 1));
      wdat_valid = 1'b1; wdat_data = d;
      forever begin
        #1 ok = wdat_ready;
        @(negedge clk);
        if (ok) break;
      end
      beats_taken++;
      exp_q.push_back({(i == len) ? 2'b11 : 2'b10, 16'h0, d});
    end
    wdat_valid = 1'b0;
  endtask

  task automatic drain_compare(input string req);
    int guard = 0;
    while (cap_q.size() < exp_q.size() && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check(cap_q.size() == exp_q.size(), {req, " flit count"}, cap_q.size(), exp_q.size());
    while (exp_q.size() > 0 && cap_q.size() > 0) begin
      logic [49:0] e, a;
      e = exp_q.pop_front();
      a = cap_q.pop_front();
      check(a === e, {req, " flit content"}, a, e);
    end
    exp_q.delete();
    cap_q.delete();
  endtask

  task automatic t_reset();
    #1;
    check(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
    check(wdat_ready === 1'b0, "R1 wdat_ready", wdat_ready, 0);
    check(flit_valid === 1'b0, "R1 flit_valid", flit_valid, 0);
  endtask

  task automatic t_single_beat();
    rdy_mode = 0;
    send_txn(32'h3000_0040, 4'd0, 32'h1111_0000);
    check(exp_q.size() == 2, "R5 expected two flits", exp_q.size(), 2);
    drain_compare("R5 R6");
  endtask

  task automatic t_burst4();
    rdy_mode = 0;
    send_txn(32'hA000_1234, 4'd3, 32'h2222_0000);
    drain_compare("R3 R4");
  endtask

  task automatic t_burst16_backpressure();
    rdy_mode = 1;
    send_txn(32'h5000_0000, 4'd15, 32'h3333_0000);
    drain_compare("R4 R7 order");
    rdy_mode = 0;
  endtask

  task automatic t_stall();
    logic [49:0] held;
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    beats_taken = 0;
    fork
      send_txn(32'hA000_0800, 4'd2, 32'h4444_0000);
      begin
        repeat (20) @(negedge clk);
        #6;
        check(beats_taken == 2, "R8 beats absorbed", beats_taken, 2);
        check(req_ready === 1'b0, "R2 closed mid packet", req_ready, 0);
        held = flit_data;
        check(flit_valid === 1'b1, "R7 valid held", flit_valid, 1);
        repeat (3) @(negedge clk);
        #6;
        check(flit_data === held, "R7 data stable", flit_data, held);
        check(held[49:48] == 2'b01, "R3 header first", held[49:48], 1);
        rdy_mode = 0;
      end
    join
    drain_compare("R8 R7");
  endtask

  task automatic t_idle_data();
    rdy_mode = 0;
    @(negedge clk);
    wdat_valid = 1'b1; wdat_data = 32'hDEAD_BEEF;
    for (int i = 0; i < 5; i++) begin
      #1;
      check(wdat_ready === 1'b0, "R9 no take idle", wdat_ready, 0);
      @(negedge clk);
    end
    wdat_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(cap_q.size() == 0, "R9 no flit", cap_q.size(), 0);
  endtask

  task automatic t_route_update();
    rdy_mode = 0;
    send_txn(32'hF000_0000, 4'd0, 32'h5555_0000);
    drain_compare("R6 reset entry zero");
    program_route(4'hA, 12'h0F3);
    send_txn(32'hA000_0010, 4'd1, 32'h6666_0000);
    drain_compare("R6 rewritten entry");
  endtask

  task automatic t_back_to_back();
    rdy_mode = 1;
    send_txn(32'h3000_0100, 4'd2, 32'h7777_0000);
    #1;
    send_txn(32'h5000_0200, 4'd0, 32'h8888_0000);
    drain_compare("R2 R3 back to back");
    @(negedge clk); #1;
    check(req_ready === 1'b1, "R2 reopened", req_ready, 1);
    rdy_mode = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) route_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    program_route(4'h3, 12'h5A1);
    program_route(4'hA, 12'h237);
    program_route(4'h5, 12'hC0E);
    t_single_beat();
    t_burst4();
    t_burst16_backpressure();
    t_stall();
    t_idle_data();
    t_route_update();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule